// File: doc/BRIEF.md
# Sleep Interval Timer with Rollover Watchdog

This block keeps a free-running interval counter that advances only on a one-cycle tick enable taken from a 32 kHz source. Each time the counter reaches the end of the selected interval it rolls over to zero. If the sleep-timer mask bit is set, the rollover raises a one-cycle interrupt pulse and latches an interrupt-pending flag. Software selects one of four intervals through a 2-bit field. A new selection is adopted only at the next rollover, so a shorter period can never skip past its terminal count.

A watchdog counts interval rollovers rather than system clocks, and it emits a one-cycle reset pulse on the third rollover after it was last cleared. Any write to the clear address restarts the watchdog alone. The value 38h written there restarts both the watchdog and the interval counter, which guarantees a full three-interval timeout.

The block also holds a sleep request flag. A request to sleep is dropped while an interrupt is pending. An unmasked rollover wakes the block by clearing the flag.

Top module: `sleep_wdt_top`

## Requirements
- R1: After reset, irq_o, wdt_rst_o and sleep_o are low, the mask bit is clear and the interval select is 00.
- R2: With interval select s, the interval lasts 64·8^s ticks (00→64, 01→512, 10→4096, 11→32768); irq_o is a one-cycle pulse in the cycle after the tick that ends the interval.
- R3: The interval counter advances only in cycles where tick_i is high; without ticks no rollover occurs.
- R4: A value written to the interval select (address 2, bits [1:0]) takes effect at the next rollover; the interval in progress keeps its old length.
- R5: A rollover drives irq_o only while bit 6 of the mask register (address 0) is set.
- R6: wdt_rst_o pulses high for one cycle, in the cycle after the third rollover following the last watchdog clear; that rollover also restarts the watchdog count.
- R7: Any write to address 1 restarts the watchdog count without touching the interval counter, and it overrides a rollover in the same cycle.
- R8: Writing 38h to address 1 restarts both the watchdog and the interval counter (a tick in that cycle is dropped), so the next rollover comes after a full interval.
- R9: Writing address 3 with bit 0 set raises sleep_o unless an interrupt is pending, in which case the write is ignored; bit 0 clear lowers sleep_o.
- R10: An unmasked rollover sets the pending flag and clears sleep_o in the same cycle as irq_o rises; a high irq_ack_i clears the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable from the 32 kHz source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 mask, 1 clear, 2 interval select, 3 sleep control |
| wr_data_i | input | 8 | Write data |
| irq_ack_i | input | 1 | Clears the interrupt-pending flag |
| irq_o | output | 1 | Interval interrupt pulse |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| sleep_o | output | 1 | Sleep request flag |

## Verification
Every output changes one register stage after its cause. irq_o and wdt_rst_o rise in the cycle after the rollover tick, and sleep_o follows a write or a wake in the next cycle. A clear written in one cycle restarts the interval, so the next interrupt appears exactly one full interval of ticks later. The bench drives inputs on the falling edge and updates its reference model on the same rising edge as the design. It compares the outputs at the following falling edge, once all three outputs have settled, and it measures the directed gaps between pulses in falling edges counted from the stimulus.

// File: rtl/swt_pkg.sv
package swt_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MASK = 2'd0,
        ADR_CLR  = 2'd1,
        ADR_CFG  = 2'd2,
        ADR_CTRL = 2'd3
    } swt_addr_e;

    localparam logic [DATA_W-1:0] CLR_BOTH_KEY = 8'h38;
    localparam int MASK_BIT  = 6;
    localparam int SLEEP_BIT = 0;
endpackage

// File: rtl/swt_interval_timer.sv
module swt_interval_timer #(
    parameter int SEL_W    = 2,
    parameter int BASE_LOG = 6,
    parameter int STEP_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_all_i,
    input  logic [SEL_W-1:0] sel_req_i,
    output logic             roll_o
);
    localparam int MAX_SEL = (1 << SEL_W) - 1;
    localparam int CNT_W   = BASE_LOG + STEP_LOG * MAX_SEL;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] act;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [CNT_W-1:0] term;
    logic             roll;
    int               sh;

    always_comb begin
        sh   = STEP_LOG * (MAX_SEL - int'(st_q.act));
        term = {CNT_W{1'b1}} >> sh;
        roll = tick_i && !clr_all_i && (st_q.cnt == term);
        st_d = st_q;
        if (clr_all_i) begin
            st_d.cnt = '0;
        end else if (roll) begin
            st_d.cnt = '0;
            st_d.act = sel_req_i;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign roll_o = roll;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) st_q.cnt <= term); // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) (!tick_i && !clr_all_i) |=> $stable(st_q.cnt)); // R3
    AST_SEL_AT_ROLL: assert property (@(posedge clk) disable iff (!rst_n) !roll |=> $stable(st_q.act)); // R4
    AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) clr_all_i |=> (st_q.cnt == '0)); // R8
endmodule

// File: rtl/swt_wdt_counter.sv
module swt_wdt_counter #(
    parameter int ROLLS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic roll_i,
    input  logic clr_i,
    output logic fire_o
);
    localparam int CW = (ROLLS > 1) ? $clog2(ROLLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ROLLS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fire;
    } wdt_t;

    wdt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (roll_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.fire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o = st_q.fire;

    AST_WDT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) st_q.fire |=> !st_q.fire); // R6
    AST_WDT_AFTER_ROLL: assert property (@(posedge clk) disable iff (!rst_n) st_q.fire |-> $past(roll_i)); // R6
    AST_WDT_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) clr_i |=> !st_q.fire); // R7
endmodule

// File: rtl/swt_regs.sv
module swt_regs
    import swt_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              irq_ack_i,
    input  logic              roll_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic              clr_wdt_o,
    output logic              clr_all_o,
    output logic              irq_o,
    output logic              sleep_o
);
    typedef struct packed {
        logic             mask;
        logic [SEL_W-1:0] sel;
        logic             irq;
        logic             pend;
        logic             sleep;
    } reg_t;

    reg_t st_d, st_q;
    logic wake;

    always_comb begin
        clr_wdt_o = wr_en_i && (wr_addr_i == ADR_CLR);
        clr_all_o = clr_wdt_o && (wr_data_i == CLR_BOTH_KEY);
        wake      = roll_i && st_q.mask;
        st_d      = st_q;
        st_d.irq  = wake;
        if (wr_en_i && wr_addr_i == ADR_MASK) st_d.mask = wr_data_i[MASK_BIT];
        if (wr_en_i && wr_addr_i == ADR_CFG)  st_d.sel  = wr_data_i[SEL_W-1:0];
        if (wake)           st_d.pend = 1'b1;
        else if (irq_ack_i) st_d.pend = 1'b0;
        if (wake) begin
            st_d.sleep = 1'b0;
        end else if (wr_en_i && wr_addr_i == ADR_CTRL) begin
            if (!wr_data_i[SLEEP_BIT])  st_d.sleep = 1'b0;
            else if (!st_q.pend)        st_d.sleep = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o   = st_q.sel;
    assign irq_o   = st_q.irq;
    assign sleep_o = st_q.sleep;

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n) st_q.irq |-> $past(st_q.mask)); // R5
    AST_PEND_BLOCKS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n) (st_q.pend && !st_q.sleep) |=> !st_q.sleep); // R9
    AST_IRQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n) st_q.irq |-> (st_q.pend && !st_q.sleep)); // R10
endmodule

// File: rtl/sleep_wdt_top.sv
module sleep_wdt_top
    import swt_pkg::*;
#(
    parameter int SEL_W     = 2,
    parameter int BASE_LOG  = 6,
    parameter int STEP_LOG  = 3,
    parameter int WDT_ROLLS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              irq_ack_i,
    output logic              irq_o,
    output logic              wdt_rst_o,
    output logic              sleep_o
);
    logic [SEL_W-1:0] sel_req;
    logic             clr_wdt, clr_all, roll;

    swt_regs #(.SEL_W(SEL_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .irq_ack_i (irq_ack_i),
        .roll_i    (roll),
        .sel_o     (sel_req),
        .clr_wdt_o (clr_wdt),
        .clr_all_o (clr_all),
        .irq_o     (irq_o),
        .sleep_o   (sleep_o)
    );

    swt_interval_timer #(
        .SEL_W    (SEL_W),
        .BASE_LOG (BASE_LOG),
        .STEP_LOG (STEP_LOG)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .clr_all_i (clr_all),
        .sel_req_i (sel_req),
        .roll_o    (roll)
    );

    swt_wdt_counter #(.ROLLS(WDT_ROLLS)) i_wdt (
        .clk    (clk),
        .rst_n  (rst_n),
        .roll_i (roll),
        .clr_i  (clr_wdt),
        .fire_o (wdt_rst_o)
    );

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |=> !irq_o); // R2
    AST_IRQ_FROM_ROLL: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> $past(roll)); // R2
    AST_NO_ROLL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !tick_i |-> !roll); // R3
endmodule

// File: tb/test_sleep_wdt_top.sv
module test_sleep_wdt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ack = 1'b0;
    logic       irq, wdt, slp;

    int checks = 0;
    int errors = 0;
    int tick_mode = 0;
    int tick_div = 0;
    int cyc = 0;
    int irq_cnt = 0;
    int wdt_cnt = 0;
    bit done = 1'b0;

    // reference model state
    int m_cnt, m_act, m_sel, m_w;
    bit m_mask, m_pend, m_sleep, m_irq, m_wdt;

    always #4 clk = ~clk;

    sleep_wdt_top i_sleep_wdt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .irq_ack_i (ack),
        .irq_o     (irq),
        .wdt_rst_o (wdt),
        .sleep_o   (slp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 3;
        tick <= (tick_mode == 1) || (tick_mode == 2 && tick_div == 0);
    end

    always @(posedge clk) begin
        bit wc, magic, roll, wake;
        int per;
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_sel = 0; m_w = 0;
            m_mask = 0; m_pend = 0; m_sleep = 0; m_irq = 0; m_wdt = 0;
        end else begin
            per   = 64 << (3 * m_act);
            wc    = wr_en && wr_addr == 2'd1;
            magic = wc && wr_data == 8'h38;
            roll  = !magic && tick && (m_cnt == per - 1);
            wake  = roll && m_mask;
            m_irq = wake;
            m_wdt = 0;
            if (wc) m_w = 0;
            else if (roll) begin
                if (m_w == 2) begin m_w = 0; m_wdt = 1; end
                else m_w = m_w + 1;
            end
            if (magic || roll) m_cnt = 0;
            else if (tick) m_cnt = m_cnt + 1;
            if (roll) m_act = m_sel;
            if (wr_en && wr_addr == 2'd2) m_sel = int'(wr_data[1:0]);
            if (wake) m_sleep = 0;
            else if (wr_en && wr_addr == 2'd3) begin
                if (!wr_data[0]) m_sleep = 0;
                else if (!m_pend) m_sleep = 1;
            end
            if (wake) m_pend = 1;
            else if (ack) m_pend = 0;
            if (wr_en && wr_addr == 2'd0) m_mask = wr_data[6];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq == m_irq, "R2", int'(irq), int'(m_irq), "irq_o vs model");
            chk(wdt == m_wdt, "R6", int'(wdt), int'(m_wdt), "wdt_rst_o vs model");
            chk(slp == m_sleep, "R9", int'(slp), int'(m_sleep), "sleep_o vs model");
            if (irq) irq_cnt++;
            if (wdt) wdt_cnt++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL R1 watchdog expired: actual=%0d expected<150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 40000);
    endtask

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 0, "R1", int'(irq), 0, "irq_o after reset");
        chk(wdt == 0, "R1", int'(wdt), 0, "wdt_rst_o after reset");
        chk(slp == 0, "R1", int'(slp), 0, "sleep_o after reset");

        // R3: no ticks, no rollovers even with mask set
        wr(2'd0, 8'h40);
        irq_cnt = 0;
        repeat (300) @(negedge clk);
        chk(irq_cnt == 0, "R3", irq_cnt, 0, "irq count without ticks");
        tick_mode = 2;
        repeat (700) @(negedge clk);
        chk(irq_cnt > 0, "R3", irq_cnt, 1, "irq count with sparse ticks");

        // R8 / R2: key write restarts the interval
        tick_mode = 1;
        wr(2'd1, 8'h38);
        repeat (63) @(negedge clk);
        chk(irq == 0, "R8", int'(irq), 0, "irq before full interval after key");
        @(negedge clk);
        chk(irq == 1, "R8", int'(irq), 1, "irq at 64 ticks after key");
        wait_irq(n);
        chk(n == 64, "R2", n, 64, "interval gap for select 00");

        // R5: masked off
        wr(2'd0, 8'h00);
        irq_cnt = 0;
        repeat (200) @(negedge clk);
        chk(irq_cnt == 0, "R5", irq_cnt, 0, "irq count with mask clear");
        wr(2'd0, 8'h40);

        // R6: watchdog on third rollover after clear
        wr(2'd1, 8'h38);
        wdt_cnt = 0;
        repeat (191) @(negedge clk);
        chk(wdt_cnt == 0, "R6", wdt_cnt, 0, "wdt before third rollover");
        @(negedge clk);
        chk(wdt == 1, "R6", int'(wdt), 1, "wdt at third rollover");
        @(negedge clk);
        chk(wdt == 0, "R6", int'(wdt), 0, "wdt pulse width");

        // R7: plain clears keep the watchdog quiet, interval keeps running
        wdt_cnt = 0;
        irq_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            repeat (100) @(negedge clk);
            wr(2'd1, 8'h00);
        end
        chk(wdt_cnt == 0, "R7", wdt_cnt, 0, "wdt count under plain clears");
        chk(irq_cnt >= 12, "R7", irq_cnt, 12, "interval not reset by plain clear");

        // R4: select change waits for the next rollover
        wr(2'd1, 8'h38);
        repeat (10) @(negedge clk);
        wr(2'd2, 8'h01);
        wait_irq(n);
        chk(n == 52, "R4", n, 52, "old interval finishes after select write");
        wait_irq(n);
        chk(n == 512, "R4", n, 512, "new interval length select 01");

        // R9 / R10: sleep flag and pending interrupt
        pulse_ack();
        wr(2'd3, 8'h01);
        chk(slp == 1, "R9", int'(slp), 1, "sleep set with nothing pending");
        wait_irq(n);
        chk(slp == 0, "R10", int'(slp), 0, "unmasked rollover wakes");
        wr(2'd3, 8'h01);
        chk(slp == 0, "R9", int'(slp), 0, "sleep write ignored while pending");
        pulse_ack();
        wr(2'd3, 8'h01);
        chk(slp == 1, "R10", int'(slp), 1, "sleep accepted after ack");
        wr(2'd3, 8'h00);
        chk(slp == 0, "R9", int'(slp), 0, "sleep cleared by write of 0");

        // R2: longest interval
        wr(2'd2, 8'h03);
        wait_irq(n);
        wait_irq(n);
        chk(n == 32768, "R2", n, 32768, "interval gap for select 11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule